// File: doc/BRIEF.md
# Whole-Array Erase Sequence Controller

This block watches the three control lines of a byte-wide parallel EEPROM model and recognises the pin-level sequence that clears the whole array. The high voltage on output enable is not sensed: an input flag reports that the line is at the elevated level. When the sequence meets every timing limit, the block writes FFh into every location of a small behavioural register file. It then flags that the erase was accepted and stays busy through the recovery interval.

Every interval is a minimum, given in nanoseconds and turned into clock cycles from a clock-frequency parameter. There are four limits: chip-enable setup before write enable falls, high-voltage setup before write enable rises, the low width of write enable, and the recovery time after the rise. A broken rule ends the attempt with a one-cycle error pulse, and the array keeps its contents. A load port and a combinational read port give the surrounding model and the bench access to the array contents.

Top module: `erase_seq_ctrl`

## Requirements
- R1: After reset, busy_o, done_o and err_o are low and every byte of the array reads 00h.
- R2: The erase is accepted under four conditions. Chip enable is low for at least CE_CYC sampled cycles before write enable is first sampled low. Write enable then stays low for at least PULSE_CYC samples. The high-voltage flag is high for at least OE_CYC consecutive samples up to and including the rise of write enable. Chip enable stays low until that rise. On acceptance, done_o pulses for one cycle in the cycle after the edge that samples write enable high, and every byte then reads FFh. Each cycle count is ceil(ns * CLK_HZ / 1e9), and never less than 1.
- R3: A write enable fall with chip enable low for fewer than CE_CYC samples gives an err_o pulse in the cycle after the fall is sampled, and the array is unchanged.
- R4: A write enable low width below PULSE_CYC gives an err_o pulse in the cycle after the rise is sampled, and the array is unchanged.
- R5: A high-voltage setup below OE_CYC samples at the rise of write enable gives an err_o pulse in the cycle after the rise, and the array is unchanged.
- R6: If the high-voltage flag goes high and then drops while write enable is low, err_o pulses in the cycle after the drop is sampled, and the array is unchanged.
- R7: Chip enable rising while write enable is still low gives an err_o pulse in the cycle after. Chip enable rising on the same edge as write enable (zero hold) still lets the erase through.
- R8: busy_o is high for exactly REC_CYC cycles, starting with the done_o cycle. err_o and done_o never pulse together, and each pulse lasts one cycle.
- R9: While busy_o is high, a new write enable fall with chip enable low is ignored: there is no err_o, no done_o, and the length of busy_o does not change.
- R10: A write enable pulse with chip enable high is ignored, whatever its length and the high-voltage flag: there is no pulse, and the array is unchanged.
- R11: With ld_en_i high, ld_data_i is written at ld_addr_i on the clock edge. rd_data_o shows the byte at rd_addr_i combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_n_i | input | 1 | Chip enable, active low |
| we_n_i | input | 1 | Write enable, active low |
| oe_hv_i | input | 1 | Output enable is at the high-voltage level |
| ld_en_i | input | 1 | Array load strobe |
| ld_addr_i | input | AW | Load address |
| ld_data_i | input | DW | Load data |
| rd_addr_i | input | AW | Read address |
| rd_data_o | output | DW | Byte at rd_addr_i |
| busy_o | output | 1 | Recovery interval running |
| done_o | output | 1 | One-cycle pulse: erase accepted |
| err_o | output | 1 | One-cycle pulse: sequence rejected |

## Verification
done_o, err_o and busy_o are registered, so each one appears one cycle after the edge that samples the deciding input. That edge is the write enable fall for a chip-enable setup fault, the rise for a width or high-voltage setup fault or for acceptance, and the offending change for a mid-pulse abort. The bench drives each change on a falling clock edge and notes the cycle number. It queues the expected pulse for that number plus one, and a monitor compares both pulse outputs with the queue on every falling edge, so any pulse the queue does not hold is caught. busy_o is sampled in the first and the REC_CYC-th cycle after the rise and in the cycle after that, and the array is read back after every outcome.

// File: rtl/erase_pkg.sv
package erase_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PULSE = 2'd1,
    ST_RECOV = 2'd2
  } erase_st_e;

  // ceil(ns * hz / 1e9), at least one cycle
  function automatic longint unsigned ns_to_cyc(longint unsigned ns, longint unsigned hz);
    longint unsigned c;
    c = (ns * hz + 64'd999_999_999) / 64'd1_000_000_000;
    if (c == 0) c = 1;
    return c;
  endfunction

endpackage

// File: rtl/erase_sat_cnt.sv
module erase_sat_cnt #(
  parameter int unsigned W   = 8,
  parameter int unsigned MAX = 255
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  output logic [W-1:0] cnt_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_o <= '0;
    else if (clr_i)              cnt_o <= '0;
    else if (cnt_o != W'(MAX))   cnt_o <= cnt_o + 1'b1;
  end

endmodule

// File: rtl/erase_fsm.sv
module erase_fsm
  import erase_pkg::*;
#(
  parameter int unsigned CNT_W     = 8,
  parameter int unsigned CE_CYC    = 1,
  parameter int unsigned OE_CYC    = 1,
  parameter int unsigned PULSE_CYC = 1,
  parameter int unsigned REC_CYC   = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ce_n_i,
  input  logic             we_n_i,
  input  logic             oe_hv_i,
  input  logic [CNT_W-1:0] ce_cnt_i,
  input  logic [CNT_W-1:0] we_cnt_i,
  input  logic [CNT_W-1:0] oe_cnt_i,
  input  logic [CNT_W-1:0] rec_cnt_i,
  output erase_st_e        st_o,
  output logic             fill_o,
  output logic             done_o,
  output logic             err_o
);

  erase_st_e st_q, st_d;
  logic      we_n_q, done_d, err_d;
  logic      we_fall;

  assign we_fall = we_n_q & ~we_n_i;

  always_comb begin
    st_d   = st_q;
    done_d = 1'b0;
    err_d  = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (we_fall && !ce_n_i) begin
          if (ce_cnt_i >= CNT_W'(CE_CYC)) st_d  = ST_PULSE;
          else                            err_d = 1'b1;
        end
      end
      ST_PULSE: begin
        if (we_n_i) begin
          // rise of write enable: judge the whole sequence
          if (we_cnt_i >= CNT_W'(PULSE_CYC) && oe_cnt_i >= CNT_W'(OE_CYC) && oe_hv_i) begin
            st_d   = ST_RECOV;
            done_d = 1'b1;
          end else begin
            st_d  = ST_IDLE;
            err_d = 1'b1;
          end
        end else if (ce_n_i || (oe_cnt_i != '0 && !oe_hv_i)) begin
          st_d  = ST_IDLE;
          err_d = 1'b1;
        end
      end
      ST_RECOV: begin
        if (rec_cnt_i == CNT_W'(REC_CYC - 1)) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      we_n_q <= 1'b1;
      done_o <= 1'b0;
      err_o  <= 1'b0;
    end else begin
      st_q   <= st_d;
      we_n_q <= we_n_i;
      done_o <= done_d;
      err_o  <= err_d;
    end
  end

  assign st_o   = st_q;
  assign fill_o = done_d;

endmodule

// File: rtl/erase_array.sv
module erase_array #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned DW    = 8,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          fill_i,
  input  logic          ld_en_i,
  input  logic [AW-1:0] ld_addr_i,
  input  logic [DW-1:0] ld_data_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [DW-1:0] rd_data_o
);

  logic [DW-1:0] mem_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_row
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 mem_q[i] <= '0;
      else if (fill_i)                             mem_q[i] <= '1;
      else if (ld_en_i && ld_addr_i == AW'(i))     mem_q[i] <= ld_data_i;
    end
  end

  if (DEPTH == (1 << AW)) begin : g_rd_pow2
    assign rd_data_o = mem_q[rd_addr_i];
  end else begin : g_rd_guard
    assign rd_data_o = (32'(rd_addr_i) < DEPTH) ? mem_q[rd_addr_i] : '0;
  end

endmodule

// File: rtl/erase_seq_ctrl.sv
module erase_seq_ctrl
  import erase_pkg::*;
#(
  parameter int unsigned      DEPTH       = 16,
  parameter int unsigned      DW          = 8,
  parameter longint unsigned  CLK_HZ      = 100_000_000,
  parameter longint unsigned  CE_SETUP_NS = 1_000,
  parameter longint unsigned  OE_SETUP_NS = 1_000,
  parameter longint unsigned  PULSE_NS    = 10_000_000,
  parameter longint unsigned  RECOV_NS    = 3_000_000,
  localparam int unsigned     AW          = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ce_n_i,
  input  logic          we_n_i,
  input  logic          oe_hv_i,
  input  logic          ld_en_i,
  input  logic [AW-1:0] ld_addr_i,
  input  logic [DW-1:0] ld_data_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [DW-1:0] rd_data_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          err_o
);

  localparam int unsigned CE_CYC    = 32'(ns_to_cyc(CE_SETUP_NS, CLK_HZ));
  localparam int unsigned OE_CYC    = 32'(ns_to_cyc(OE_SETUP_NS, CLK_HZ));
  localparam int unsigned PULSE_CYC = 32'(ns_to_cyc(PULSE_NS, CLK_HZ));
  localparam int unsigned REC_CYC   = 32'(ns_to_cyc(RECOV_NS, CLK_HZ));
  localparam int unsigned MAX_A     = (CE_CYC > OE_CYC) ? CE_CYC : OE_CYC;
  localparam int unsigned MAX_B     = (PULSE_CYC > REC_CYC) ? PULSE_CYC : REC_CYC;
  localparam int unsigned MAX_CYC   = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int unsigned CNT_W     = $clog2(MAX_CYC + 1);
  localparam int unsigned NCNT      = 4;
  localparam int unsigned CI_CE     = 0;
  localparam int unsigned CI_WE     = 1;
  localparam int unsigned CI_OE     = 2;
  localparam int unsigned CI_REC    = 3;

  erase_st_e        st;
  logic             fill;
  logic [NCNT-1:0]  cnt_clr;
  logic [CNT_W-1:0] cnt_q [NCNT];

  // each counter holds consecutive samples of its condition
  assign cnt_clr[CI_CE]  = ce_n_i;
  assign cnt_clr[CI_WE]  = we_n_i;
  assign cnt_clr[CI_OE]  = ~oe_hv_i;
  assign cnt_clr[CI_REC] = (st != ST_RECOV);

  for (genvar k = 0; k < NCNT; k++) begin : g_cnt
    erase_sat_cnt #(
      .W   (CNT_W),
      .MAX (MAX_CYC)
    ) u_cnt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (cnt_clr[k]),
      .cnt_o  (cnt_q[k])
    );
  end

  erase_fsm #(
    .CNT_W     (CNT_W),
    .CE_CYC    (CE_CYC),
    .OE_CYC    (OE_CYC),
    .PULSE_CYC (PULSE_CYC),
    .REC_CYC   (REC_CYC)
  ) u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ce_n_i    (ce_n_i),
    .we_n_i    (we_n_i),
    .oe_hv_i   (oe_hv_i),
    .ce_cnt_i  (cnt_q[CI_CE]),
    .we_cnt_i  (cnt_q[CI_WE]),
    .oe_cnt_i  (cnt_q[CI_OE]),
    .rec_cnt_i (cnt_q[CI_REC]),
    .st_o      (st),
    .fill_o    (fill),
    .done_o    (done_o),
    .err_o     (err_o)
  );

  erase_array #(
    .DEPTH (DEPTH),
    .DW    (DW)
  ) u_array (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .fill_i    (fill),
    .ld_en_i   (ld_en_i),
    .ld_addr_i (ld_addr_i),
    .ld_data_i (ld_data_i),
    .rd_addr_i (rd_addr_i),
    .rd_data_o (rd_data_o)
  );

  assign busy_o = (st == ST_RECOV);

endmodule

// File: rtl/erase_seq_checker.sv
module erase_seq_checker #(
  parameter int unsigned REC_CYC = 1
) (
  input logic clk_i,
  input logic rst_ni,
  input logic we_n_i,
  input logic busy_o,
  input logic done_o,
  input logic err_o
);

  int unsigned busy_run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     busy_run <= 0;
    else if (busy_o) busy_run <= busy_run + 1;
    else             busy_run <= 0;
  end

  a_r2_done_opens_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> busy_o);

  a_r2_done_after_we_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($past(we_n_i) && !$past(we_n_i, 2)));

  a_r8_busy_length: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (busy_run == REC_CYC));

  a_r8_busy_starts_with_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> done_o);

  a_r8_pulses_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && err_o));

  a_r8_err_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> !err_o);

  a_r9_quiet_in_recovery: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> (!done_o && !err_o));

endmodule

bind erase_seq_ctrl erase_seq_checker #(
  .REC_CYC (REC_CYC)
) u_erase_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .we_n_i (we_n_i),
  .busy_o (busy_o),
  .done_o (done_o),
  .err_o  (err_o)
);

// File: tb/test_erase_seq_ctrl.sv
module test_erase_seq_ctrl;

  localparam int DEPTH = 16;
  localparam int DW    = 8;
  localparam int AW    = 4;
  // 250 MHz: 40 ns -> 10 cycles, 400 ns -> 100, 120 ns -> 30
  localparam int T_CE  = 10;
  localparam int T_OE  = 10;
  localparam int T_PW  = 100;
  localparam int T_REC = 30;

  typedef struct {
    int    cyc;
    bit    done;
    bit    err;
    string req;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ce_n = 1'b1, we_n = 1'b1, oe_hv = 1'b0;
  logic          ld_en = 1'b0;
  logic [AW-1:0] ld_addr = '0, rd_addr = '0;
  logic [DW-1:0] ld_data = '0;
  logic [DW-1:0] rd_data;
  logic          busy, done, err;

  int    cyc = 0;
  int    checks = 0;
  int    errors = 0;
  string cur_req = "R1";
  exp_t  q[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  erase_seq_ctrl #(
    .DEPTH       (DEPTH),
    .DW          (DW),
    .CLK_HZ      (250_000_000),
    .CE_SETUP_NS (40),
    .OE_SETUP_NS (40),
    .PULSE_NS    (400),
    .RECOV_NS    (120)
  ) i_erase_seq_ctrl (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .ce_n_i    (ce_n),
    .we_n_i    (we_n),
    .oe_hv_i   (oe_hv),
    .ld_en_i   (ld_en),
    .ld_addr_i (ld_addr),
    .ld_data_i (ld_data),
    .rd_addr_i (rd_addr),
    .rd_data_o (rd_data),
    .busy_o    (busy),
    .done_o    (done),
    .err_o     (err)
  );

  function automatic logic [DW-1:0] pat(int a);
    return DW'(a * 37 + 5);
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // scoreboard monitor: pulse outputs against queued expectations
  always @(negedge clk) begin
    if (rst_n) begin
      bit    ed, ee, hit;
      string tag;
      ed = 1'b0; ee = 1'b0; hit = 1'b0; tag = cur_req;
      if (q.size() > 0 && q[0].cyc == cyc) begin
        ed = q[0].done; ee = q[0].err; tag = q[0].req; hit = 1'b1;
        void'(q.pop_front());
      end
      if (hit || done || err) begin
        checks++;
        if (done !== ed || err !== ee) begin
          errors++;
          $display("FAIL %s pulses done/err actual=%0b%0b expected=%0b%0b", tag, done, err, ed, ee);
        end
      end
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push(bit d, bit e, string req);
    exp_t x;
    x.cyc = cyc + 1; x.done = d; x.err = e; x.req = req;
    q.push_back(x);
  endtask

  task automatic load_pattern();
    for (int a = 0; a < DEPTH; a++) begin
      @(negedge clk);
      ld_en = 1'b1; ld_addr = AW'(a); ld_data = pat(a);
    end
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic check_array(bit ff, string req);
    for (int a = 0; a < DEPTH; a++) begin
      logic [DW-1:0] e;
      rd_addr = AW'(a);
      #0.5;
      e = ff ? '1 : pat(a);
      chk(rd_data === e, req, "array byte", int'(rd_data), int'(e));
    end
  endtask

  // mode 0: plain, 1: high-voltage drop mid-pulse, 2: chip enable rise mid-pulse,
  // 3: chip enable rises with write enable
  task automatic do_seq(int ce_su, int we_lo, int oe_su, int mode, string req);
    bit ok;
    cur_req = req;
    @(negedge clk);
    ce_n = 1'b0; oe_hv = 1'b0;
    step(ce_su);
    we_n = 1'b0;
    if (ce_su < T_CE) begin
      push(1'b0, 1'b1, req);
      step(we_lo);
      we_n = 1'b1; ce_n = 1'b1;
      step(4);
      chk(busy === 1'b0, req, "busy after rejected fall", busy, 0);
      check_array(1'b0, req);
      return;
    end
    if (mode == 2) begin
      step(20);
      ce_n = 1'b1;
      push(1'b0, 1'b1, req);
      step(we_lo - 20);
      we_n = 1'b1;
    end else begin
      step(we_lo - oe_su);
      oe_hv = 1'b1;
      if (mode == 1) begin
        step(3);
        oe_hv = 1'b0;
        push(1'b0, 1'b1, req);
        step(oe_su - 3);
        we_n = 1'b1;
      end else begin
        step(oe_su);
        we_n = 1'b1;
        if (mode == 3) ce_n = 1'b1;
        ok = (we_lo >= T_PW) && (oe_su >= T_OE);
        push(ok, !ok, req);
      end
    end
    if (mode == 1 || mode == 2) ok = 1'b0;
    if (ok) begin
      int pulses;
      pulses = 0;
      step(1);
      ce_n = 1'b1; oe_hv = 1'b0;
      chk(busy === 1'b1, "R8", "busy in done cycle", busy, 1);
      step(1);
      // R9: new attempt during recovery
      cur_req = "R9";
      ce_n = 1'b0; we_n = 1'b0;
      for (int i = 0; i < T_REC - 7; i++) begin
        step(1);
        if (done || err) pulses++;
      end
      we_n = 1'b1; ce_n = 1'b1;
      for (int i = 0; i < 5; i++) begin
        step(1);
        if (done || err) pulses++;
      end
      chk(pulses == 0, "R9", "pulses during recovery", pulses, 0);
      chk(busy === 1'b1, "R8", "busy in last recovery cycle", busy, 1);
      step(1);
      chk(busy === 1'b0, "R8", "busy after recovery", busy, 0);
      check_array(1'b1, "R2");
    end else begin
      step(1);
      ce_n = 1'b1; oe_hv = 1'b0; we_n = 1'b1;
      step(3);
      chk(busy === 1'b0, req, "busy after rejection", busy, 0);
      check_array(1'b0, req);
    end
    step(3);
  endtask

  initial begin
    repeat (150_000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete (R1..R11 pending)");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    step(3);
    // R1 reset state
    chk(busy === 1'b0, "R1", "busy in reset", busy, 0);
    chk(done === 1'b0 && err === 1'b0, "R1", "pulses in reset", {done, err}, 0);
    rst_n = 1'b1;
    step(2);
    for (int a = 0; a < DEPTH; a++) begin
      rd_addr = AW'(a);
      #0.5;
      chk(rd_data === '0, "R1", "array after reset", int'(rd_data), 0);
    end

    // R11 load and read
    cur_req = "R11";
    load_pattern();
    check_array(1'b0, "R11");

    do_seq(T_CE - 1, 20, T_OE, 0, "R3");
    do_seq(T_CE, T_PW - 1, T_OE, 0, "R4");
    do_seq(T_CE, T_PW, T_OE - 1, 0, "R5");
    do_seq(T_CE, T_PW, T_OE, 1, "R6");
    do_seq(T_CE, T_PW, T_OE, 2, "R7");

    // R10: long pulse with chip enable high
    cur_req = "R10";
    @(negedge clk);
    oe_hv = 1'b1; we_n = 1'b0;
    step(T_PW + 20);
    we_n = 1'b1;
    step(3);
    oe_hv = 1'b0;
    chk(busy === 1'b0 && done === 1'b0 && err === 1'b0, "R10", "outputs after deselected pulse",
        {busy, done, err}, 0);
    check_array(1'b0, "R10");

    // R2/R7: exact minimums, chip enable released on the rising edge
    do_seq(T_CE, T_PW, T_OE, 3, "R7");
    load_pattern();
    check_array(1'b0, "R11");
    // R2: longer than minimum
    do_seq(T_CE + 7, T_PW + 25, T_OE + 40, 0, "R2");

    step(5);
    chk(q.size() == 0, "R8", "unconsumed expectations", q.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule